// File: doc/BRIEF.md
# Serial Word-Synchronous Flag Unit

This block ties a small set of general-purpose flag pins to the word stream of a serial audio transmitter and receiver. Each flag pin can be set up as an input flag or an output flag. Flags follow word boundaries, not the free-running level at the pad. In input mode, the pin level is captured when the first bit of a receive word is sampled. That captured value becomes visible to software only when the received word moves into the receive data register. In output mode, software writes flag values into a holding stage. Those values reach the pins only when the transmit data register is loaded into the transmit shift register, so each flag stays aligned with the word it goes with.

The serial shifters, clocking and framing logic are outside this block and are represented by three single-cycle strobes. The strobes mark receive first-bit sampling, receive word transfer and transmit register load. Software uses a simple register port for access. The expected order for output flags is: wait for the transmitter to be empty, write the flags, then write the transmit data.

Each pin is brought out as a pad-style tri-state triple: an output value, an output enable and an input level.

Top module: `wsflag_unit`

## Requirements
- R1: After reset, the mode register, the output holding stage, the driven output stage, the input capture latch and the input status all read zero, and every pin output enable is low.
- R2: Register address 0 is the mode register, and bit i of it controls pin i. A 1 in bit i makes pin i an output, so `flag_oe[i]` is high. A 0 in bit i makes pin i an input, and its driver is released (`flag_oe[i]` low).
- R3: On a clock edge where `rx_first_bit` is high, the input capture latch takes the levels of all `flag_i` pins. At every other edge the latch keeps its value, whatever the pins do.
- R4: On a clock edge where `rx_word_xfer` is high, the input status is loaded from the capture latch and can be read at address 2 after that edge. If `rx_first_bit` is high at the same edge, the status takes the latch value from before that capture.
- R5: When `rx_word_xfer` repeats with no `rx_first_bit` in between, the status is loaded again with the same, unchanged latched value.
- R6: A write to address 1 updates only the output holding stage. This value can be read back at address 1, but `flag_o` does not change until a transmit load.
- R7: On a clock edge where `tx_load` is high, the driven stage takes the holding value and `flag_o` shows it after that edge. A holding write at that same edge is not included and goes out at the next load.
- R8: Between two `tx_load` strobes, `flag_o` stays stable, even if the holding stage is written.
- R9: Reads are combinational. Address 0 returns the mode, address 1 the holding stage, address 2 the status and address 3 returns zero. A write to address 2 or 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | NFLAG | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | NFLAG | Register read data (combinational) |
| rx_first_bit | input | 1 | Receive first-bit sampling strobe |
| rx_word_xfer | input | 1 | Receive word to data register transfer strobe |
| tx_load | input | 1 | Transmit register to shift register load strobe |
| flag_i | input | NFLAG | Pin input levels from the pads |
| flag_o | output | NFLAG | Pin output values to the pads |
| flag_oe | output | NFLAG | Pin output enables (low = high impedance) |

## Verification
The input path is driven with pin levels that change between the capture strobe and the transfer strobe. This tells a word-synchronous capture apart from one that follows the live pin. A capture and a transfer given in the same cycle show whether the status uses the latch value from before or after the capture. A repeated transfer with changed pins shows that the status is reloaded from the latch and not from the pins. On the output path, holding writes are made before a load, between loads and in the same cycle as a load. These cases separate double buffering from direct drive and check which value a simultaneous write leaves on the pins.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE  = 2'd0,
    REG_OHOLD = 2'd1,
    REG_ISTAT = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wsf_in_path.sv
module wsf_in_path #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] pin_lvl,
  input  logic             first_bit,
  input  logic             word_xfer,
  output logic [NFLAG-1:0] status_q
);
  logic [NFLAG-1:0] latch_q;
  logic             capture_evt;
  logic             publish_evt;

  assign capture_evt = first_bit;
  assign publish_evt = word_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      status_q <= '0;
    end else begin
      if (capture_evt) latch_q  <= pin_lvl;
      if (publish_evt) status_q <= latch_q;
    end
  end

  // R3: latch only moves on a capture strobe
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(latch_q));
  // R4 / R5: status takes the pre-edge latch value on a transfer
  a_r4_status_copy: assert property (@(posedge clk) disable iff (!rst_n)
    publish_evt |=> status_q == $past(latch_q));
  a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !publish_evt |=> $stable(status_q));
endmodule

// File: rtl/wsf_out_path.sv
module wsf_out_path #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_wr,
  input  logic [NFLAG-1:0] hold_data,
  input  logic             load,
  output logic [NFLAG-1:0] hold_q,
  output logic [NFLAG-1:0] drive_q
);
  logic load_evt;
  assign load_evt = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      drive_q <= '0;
    end else begin
      if (hold_wr)  hold_q  <= hold_data;
      if (load_evt) drive_q <= hold_q;
    end
  end

  // R7: load transfers the holding value present before the edge
  a_r7_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> drive_q == $past(hold_q));
  // R8: driven stage stable between loads
  a_r8_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(drive_q));
  // R6: holding stage changes only on a write
  a_r6_hold_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_wr |=> $stable(hold_q));
endmodule

// File: rtl/wsflag_unit.sv
module wsflag_unit
  import wsf_pkg::*;
#(
  parameter int NFLAG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NFLAG-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NFLAG-1:0]  rd_data,
  input  logic              rx_first_bit,
  input  logic              rx_word_xfer,
  input  logic              tx_load,
  input  logic [NFLAG-1:0]  flag_i,
  output logic [NFLAG-1:0]  flag_o,
  output logic [NFLAG-1:0]  flag_oe
);
  logic [NFLAG-1:0] mode_q;
  logic [NFLAG-1:0] hold_q;
  logic [NFLAG-1:0] drive_q;
  logic [NFLAG-1:0] status_q;
  logic             mode_wr;
  logic             hold_wr;

  function automatic logic [NFLAG-1:0] read_sel(
    input logic [ADDR_W-1:0] a,
    input logic [NFLAG-1:0]  m,
    input logic [NFLAG-1:0]  h,
    input logic [NFLAG-1:0]  s
  );
    case (reg_addr_e'(a))
      REG_MODE:  return m;
      REG_OHOLD: return h;
      REG_ISTAT: return s;
      default:   return '0;
    endcase
  endfunction

  assign mode_wr = wr_en && (reg_addr_e'(wr_addr) == REG_MODE);
  assign hold_wr = wr_en && (reg_addr_e'(wr_addr) == REG_OHOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data;
  end

  wsf_in_path #(.NFLAG(NFLAG)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (flag_i),
    .first_bit (rx_first_bit),
    .word_xfer (rx_word_xfer),
    .status_q  (status_q)
  );

  wsf_out_path #(.NFLAG(NFLAG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_wr   (hold_wr),
    .hold_data (wr_data),
    .load      (tx_load),
    .hold_q    (hold_q),
    .drive_q   (drive_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_pad
      assign flag_oe[gi] = mode_q[gi];
      assign flag_o[gi]  = drive_q[gi];
    end
  endgenerate

  assign rd_data = read_sel(rd_addr, mode_q, hold_q, status_q);

  // R2: mode register changes only through a write to its address
  a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(flag_oe));
  // R9: the spare address never returns data
  a_r9_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_e'(rd_addr) == REG_NONE) |-> rd_data == '0);
endmodule

// File: tb/wsflag_unit_test.sv
module wsflag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         rx_first_bit = 1'b0;
  logic         rx_word_xfer = 1'b0;
  logic         tx_load = 1'b0;
  logic [N-1:0] flag_i = '0;
  logic [N-1:0] flag_o;
  logic [N-1:0] flag_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsflag_unit #(.NFLAG(N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_first_bit(rx_first_bit), .rx_word_xfer(rx_word_xfer),
    .tx_load(tx_load), .flag_i(flag_i), .flag_o(flag_o), .flag_oe(flag_oe)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rx_first_bit = 0; rx_word_xfer = 0; tx_load = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
  endtask

  function automatic logic [N-1:0] rd(input logic [1:0] a);
    rd_addr = a;
    return 'x;
  endfunction

  task automatic rd_check(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    rd_check("R1 mode", 2'd0, '0);
    rd_check("R1 hold", 2'd1, '0);
    rd_check("R1 status", 2'd2, '0);
    check("R1 oe", flag_oe, '0);
    check("R1 flag_o", flag_o, '0);
  endtask

  task automatic t_mode();
    wr(2'd0, 3'b101);
    check("R2 oe follows mode", flag_oe, 3'b101);
    rd_check("R2 mode readback", 2'd0, 3'b101);
  endtask

  task automatic t_output();
    wr(2'd1, 3'b111);
    check("R6 pins unchanged by write", flag_o, 3'b000);
    rd_check("R6 hold readback", 2'd1, 3'b111);
    tx_load = 1; step();
    check("R7 load drives pins", flag_o, 3'b111);
    wr(2'd1, 3'b010);
    step();
    check("R8 stable between loads", flag_o, 3'b111);
    tx_load = 1; wr_en = 1; wr_addr = 2'd1; wr_data = 3'b001; step();
    check("R7 same-cycle write not loaded", flag_o, 3'b010);
    tx_load = 1; step();
    check("R7 next load carries write", flag_o, 3'b001);
  endtask

  task automatic t_input();
    flag_i = 3'b110; rx_first_bit = 1; step();
    flag_i = 3'b001; step();
    rx_word_xfer = 1; step();
    rd_check("R3 R4 captured at first bit", 2'd2, 3'b110);
    flag_i = 3'b011; step();
    rx_word_xfer = 1; step();
    rd_check("R5 reload unchanged latch", 2'd2, 3'b110);
    rx_first_bit = 1; rx_word_xfer = 1; step();
    rd_check("R4 simultaneous uses old latch", 2'd2, 3'b110);
    flag_i = 3'b000; rx_word_xfer = 1; step();
    rd_check("R4 R3 new capture published", 2'd2, 3'b011);
  endtask

  task automatic t_regs();
    wr(2'd2, 3'b100);
    rd_check("R9 status not writable", 2'd2, 3'b011);
    wr(2'd3, 3'b111);
    rd_check("R9 spare reads zero", 2'd3, 3'b000);
    rd_check("R9 mode untouched", 2'd0, 3'b101);
    rd_check("R9 hold untouched", 2'd1, 3'b001);
    check("R9 pins untouched", flag_o, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_mode();
    t_output();
    t_input();
    t_regs();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule